// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block accepts one memory access per lane for a group of 32 lanes that run in lockstep. It serves them from a scratchpad built as 32 independently accessible banks. Each lane's bank is computed from its word address. Lanes that hit the same bank but name different storage words are spread over successive cycles. Lanes that name the same storage word are served together, so a read of one address by many lanes costs a single cycle. A request-wide mode bit picks between two bank mappings. In the narrow mode a bank entry is one 32-bit word. In the wide mode a bank entry is a 64-bit pair of words, which changes which access strides collide.

A request is taken when `req_valid` and `req_ready` are both high at a rising clock edge. The block then runs one pass per clock until every enabled lane has been served. It pulses `rsp_done` for one cycle, with all read results on `rsp_rdata`, and accepts the next request in that same cycle. The number of passes equals the largest count of distinct storage words asked of any single bank. Within a bank, the word chosen for each pass is the one named by the lowest-numbered lane still waiting.

Top module: `sm_conflict_arbiter`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_done` is 0 and `rsp_rdata` is all zero.
- R2: In narrow mode (`req_wide`=0) the bank is address bits [4:0] and the storage word is the full address. Lane i accessing address base+i completes in one pass: `rsp_done` is high in the 1st cycle after the accepting edge.
- R3: `rsp_done` rises K cycles after the accepting edge. K is the largest number of distinct storage words requested in any one bank, and K is at least 1. For example, 32 lanes on addresses i*32+17 take 32 cycles, and lanes on addresses (i mod 4)*32 take 4 cycles.
- R4: Lanes that read the same address are served in the same pass, and every one of them returns that word.
- R5: In wide mode (`req_wide`=1) the bank is address bits [5:1] and the storage word is address bits [9:1]. Addresses 2i then finish in 1 pass, while the same pattern in narrow mode takes 2 passes. Addresses 0 and 64 in wide mode conflict, and addresses 0 and 1 share a word.
- R6: Addresses 3i in narrow mode complete in one pass.
- R7: `req_ready` is 0 from the cycle after acceptance until `rsp_done`. A `req_valid` presented meanwhile is ignored, and a write carried by it never reaches memory.
- R8: A write lane stores its data. A read served in the same pass as a write to that address returns the old contents. When several lanes write one address in one pass, the highest-numbered lane's data is kept.
- R9: `rsp_done` is high for exactly one cycle, and `rsp_rdata` holds its value until the next request is accepted.
- R10: On acceptance all of `rsp_rdata` is cleared to zero. Disabled lanes are never served and read back 0, and a request with no enabled lane finishes in 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_wide | input | 1 | 1 selects 64-bit bank entries, 0 selects 32-bit |
| lane_en | input | 32 | Per-lane access enable |
| lane_we | input | 32 | Per-lane write (1) or read (0) |
| lane_addr | input | 320 | Per-lane word address, lane i at bits [10i+9:10i] |
| lane_wdata | input | 1024 | Per-lane write data, lane i at bits [32i+31:32i] |
| rsp_done | output | 1 | One-cycle pulse when all lanes are served |
| rsp_rdata | output | 1024 | Per-lane read data, lane i at bits [32i+31:32i] |

## Verification
The hardest state to reach from the ports is a request still in its busy window while a second request is waiting at the input. Only a long, fully conflicting access opens that window. The stimulus sends 32 lanes to 32 different words of one bank, which costs 32 cycles. During those cycles it holds a competing write on `req_valid`, drops it in the same cycle that `rsp_done` is seen, and later reads the target address to show that the write never landed. Read-before-write ordering and highest-lane-wins ordering are reached by mixing reads and writes to one address inside a single pass.

// File: rtl/sm_pkg.sv
package sm_pkg;
    localparam int SM_LANES = 32;
    localparam int SM_BANKS = 32;
    localparam int SM_AW    = 10;
    localparam int SM_DW    = 32;
    localparam int SM_BW    = $clog2(SM_BANKS);
    localparam int SM_DEPTH = 1 << SM_AW;

    typedef logic [SM_AW-1:0] addr_t;
    typedef logic [SM_DW-1:0] data_t;
    typedef logic [SM_BW-1:0] bank_t;
    typedef logic [SM_LANES-1:0] lane_mask_t;

    typedef enum logic {ST_IDLE, ST_BUSY} arb_state_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        data_t wdata;
    } lane_req_t;

    // Bank index: narrow mode uses the low address bits, wide mode skips bit 0.
    function automatic bank_t bank_of(input addr_t a, input logic wide);
        bank_of = wide ? a[SM_BW:1] : a[SM_BW-1:0];
    endfunction

    // Storage-word identity inside a bank: wide mode pairs adjacent words.
    function automatic addr_t key_of(input addr_t a, input logic wide);
        key_of = wide ? {1'b0, a[SM_AW-1:1]} : a;
    endfunction
endpackage

// File: rtl/sm_bank_pick.sv
module sm_bank_pick
    import sm_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  lane_mask_t pending,
    input  bank_t      lane_bank [SM_LANES],
    input  addr_t      lane_key  [SM_LANES],
    output lane_mask_t hit
);
    localparam bank_t MY_BANK = bank_t'(BANK_ID);

    logic  found;
    addr_t lead_key;

    // Leader is the lowest waiting lane that maps to this bank.
    always_comb begin
        found    = 1'b0;
        lead_key = '0;
        for (int i = 0; i < SM_LANES; i++) begin
            if (!found && pending[i] && lane_bank[i] == MY_BANK) begin
                found    = 1'b1;
                lead_key = lane_key[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < SM_LANES; i++) begin
            hit[i] = pending[i] && (lane_bank[i] == MY_BANK) && (lane_key[i] == lead_key);
        end
    end
endmodule

// File: rtl/sm_pass_select.sv
module sm_pass_select
    import sm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wide,
    input  lane_mask_t pending,
    input  lane_req_t  reqs [SM_LANES],
    output lane_mask_t serve
);
    bank_t      lane_bank [SM_LANES];
    addr_t      lane_key  [SM_LANES];
    lane_mask_t bank_hit  [SM_BANKS];

    always_comb begin
        for (int i = 0; i < SM_LANES; i++) begin
            lane_bank[i] = bank_of(reqs[i].addr, wide);
            lane_key[i]  = key_of(reqs[i].addr, wide);
        end
    end

    for (genvar b = 0; b < SM_BANKS; b++) begin : g_bank
        sm_bank_pick #(.BANK_ID(b)) u_pick (
            .pending   (pending),
            .lane_bank (lane_bank),
            .lane_key  (lane_key),
            .hit       (bank_hit[b])
        );
    end

    always_comb begin
        serve = '0;
        for (int b = 0; b < SM_BANKS; b++) begin
            serve = serve | bank_hit[b];
        end
    end

    // R3: a pass only serves lanes that are still waiting
    p_serve_subset_r3: assert property (@(posedge clk) disable iff (rst)
        (serve & ~pending) == '0);

    // R3: while lanes wait, each pass serves at least one of them
    p_progress_r3: assert property (@(posedge clk) disable iff (rst)
        (pending != '0) |-> (serve != '0));
endmodule

// File: rtl/sm_word_store.sv
module sm_word_store
    import sm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  lane_mask_t serve,
    input  lane_req_t  reqs [SM_LANES],
    output data_t      rdata [SM_LANES]
);
    data_t mem [SM_DEPTH];

    // Later lanes overwrite earlier ones for the same address in a pass.
    always_ff @(posedge clk) begin
        for (int i = 0; i < SM_LANES; i++) begin
            if (serve[i] && reqs[i].we) begin
                mem[reqs[i].addr] <= reqs[i].wdata;
            end
        end
    end

    // Reads see the contents from before this pass's writes.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < SM_LANES; i++) rdata[i] <= '0;
        end else begin
            for (int i = 0; i < SM_LANES; i++) begin
                if (serve[i] && !reqs[i].we) begin
                    rdata[i] <= mem[reqs[i].addr];
                end
            end
        end
    end
endmodule

// File: rtl/sm_conflict_arbiter.sv
module sm_conflict_arbiter
    import sm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_wide,
    input  logic [SM_LANES-1:0]      lane_en,
    input  logic [SM_LANES-1:0]      lane_we,
    input  logic [SM_LANES*SM_AW-1:0] lane_addr,
    input  logic [SM_LANES*SM_DW-1:0] lane_wdata,
    output logic                     rsp_done,
    output logic [SM_LANES*SM_DW-1:0] rsp_rdata
);
    arb_state_t state;
    logic       wide_q;
    lane_mask_t pending;
    lane_mask_t serve;
    lane_mask_t serve_act;
    lane_mask_t remain;
    lane_req_t  req_q [SM_LANES];
    data_t      rd    [SM_LANES];
    logic       accept;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign serve_act = (state == ST_BUSY) ? serve : '0;
    assign remain    = pending & ~serve_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wide_q   <= 1'b0;
            pending  <= '0;
            rsp_done <= 1'b0;
            for (int i = 0; i < SM_LANES; i++) req_q[i] <= '0;
        end else begin
            rsp_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        wide_q  <= req_wide;
                        pending <= lane_en;
                        for (int i = 0; i < SM_LANES; i++) begin
                            req_q[i].we    <= lane_we[i];
                            req_q[i].addr  <= lane_addr[i*SM_AW +: SM_AW];
                            req_q[i].wdata <= lane_wdata[i*SM_DW +: SM_DW];
                        end
                        state <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    pending <= remain;
                    if (remain == '0) begin
                        state    <= ST_IDLE;
                        rsp_done <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    sm_pass_select u_select (
        .clk     (clk),
        .rst     (rst),
        .wide    (wide_q),
        .pending (pending),
        .reqs    (req_q),
        .serve   (serve)
    );

    sm_word_store u_store (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .serve (serve_act),
        .reqs  (req_q),
        .rdata (rd)
    );

    always_comb begin
        for (int i = 0; i < SM_LANES; i++) rsp_rdata[i*SM_DW +: SM_DW] = rd[i];
    end

    // R9: completion is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R7: no new lane joins the waiting set while a request is in flight
    p_hold_pending_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY) |=> ((pending & ~$past(pending)) == '0));

    // R10: completion only with every lane served and the block idle again
    p_done_empty_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (pending == '0 && req_ready));

    // R10: accepted request starts from cleared read data
    p_clear_on_accept_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> (rsp_rdata == '0));
endmodule

// File: tb/sm_conflict_arbiter_tb.sv
module sm_conflict_arbiter_tb;
    import sm_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_wide = 1'b0;
    logic [SM_LANES-1:0] lane_en = '0;
    logic [SM_LANES-1:0] lane_we = '0;
    logic [SM_LANES*SM_AW-1:0] lane_addr = '0;
    logic [SM_LANES*SM_DW-1:0] lane_wdata = '0;
    logic rsp_done;
    logic [SM_LANES*SM_DW-1:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic        b_en [SM_LANES];
    logic        b_we [SM_LANES];
    int          b_ad [SM_LANES];
    logic [31:0] b_wd [SM_LANES];
    logic [31:0] got  [SM_LANES];

    always #10 clk = ~clk;

    sm_conflict_arbiter u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_wide(req_wide), .lane_en(lane_en), .lane_we(lane_we),
        .lane_addr(lane_addr), .lane_wdata(lane_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [31:0] mval(input int a);
        mval = 32'h5A00_0000 + 32'(a) * 32'd3;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_lanes();
        for (int i = 0; i < SM_LANES; i++) begin
            b_en[i] = 1'b0; b_we[i] = 1'b0; b_ad[i] = 0; b_wd[i] = '0;
        end
    endtask

    // Issue the staged request, count cycles to done, optionally push a competing write.
    task automatic run(input logic wide, input int exp_passes, input string tag, input bit inject);
        int  cnt;
        bit  ready_seen;
        @(negedge clk);
        req_wide = wide;
        for (int i = 0; i < SM_LANES; i++) begin
            lane_en[i] = b_en[i];
            lane_we[i] = b_we[i];
            lane_addr[i*SM_AW +: SM_AW] = SM_AW'(b_ad[i]);
            lane_wdata[i*SM_DW +: SM_DW] = b_wd[i];
        end
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            lane_en = 32'h1; lane_we = 32'h1;
            lane_addr[SM_AW-1:0] = SM_AW'(10);
            lane_wdata[SM_DW-1:0] = 32'hDEAD_BEEF;
            req_valid = 1'b1;
        end
        cnt = 0;
        ready_seen = 1'b0;
        while (1) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (rsp_done || cnt > 200) break;
            if (req_ready) ready_seen = 1'b1;
        end
        req_valid = 1'b0;
        check({tag, " passes"}, 32'(cnt), 32'(exp_passes));
        check("R7 ready low while busy", 32'(ready_seen), 32'd0);
        for (int i = 0; i < SM_LANES; i++) got[i] = rsp_rdata[i*SM_DW +: SM_DW];
        @(negedge clk);
        check("R9 done single pulse", 32'(rsp_done), 32'd0);
        check("R9 rdata held", rsp_rdata[SM_DW-1:0], got[0]);
    endtask

    task automatic t_reset();
        check("R1 ready after reset", 32'(req_ready), 32'd1);
        check("R1 done after reset", 32'(rsp_done), 32'd0);
        check("R1 rdata after reset", 32'(rsp_rdata != '0), 32'd0);
    endtask

    task automatic t_fill();
        for (int base = 0; base < 128; base += 32) begin
            clear_lanes();
            for (int i = 0; i < SM_LANES; i++) begin
                b_en[i] = 1'b1; b_we[i] = 1'b1; b_ad[i] = base + i; b_wd[i] = mval(base + i);
            end
            run(1'b0, 1, "R2 linear write", 1'b0);
        end
    endtask

    task automatic t_linear_read();
        clear_lanes();
        for (int i = 0; i < SM_LANES; i++) begin b_en[i] = 1'b1; b_ad[i] = 64 + i; end
        run(1'b0, 1, "R2 linear read", 1'b0);
        for (int i = 0; i < SM_LANES; i++) check("R2 linear data", got[i], mval(64 + i));
    endtask

    task automatic t_stride2();
        clear_lanes();
        for (int i = 0; i < SM_LANES; i++) begin b_en[i] = 1'b1; b_ad[i] = 2 * i; end
        run(1'b0, 2, "R5 stride2 narrow", 1'b0);
        for (int i = 0; i < SM_LANES; i++) check("R5 stride2 narrow data", got[i], mval(2 * i));
        run(1'b1, 1, "R5 stride2 wide", 1'b0);
        for (int i = 0; i < SM_LANES; i++) check("R5 stride2 wide data", got[i], mval(2 * i));
    endtask

    task automatic t_wide_conflict();
        clear_lanes();
        b_en[0] = 1'b1; b_ad[0] = 0;
        b_en[1] = 1'b1; b_ad[1] = 64;
        b_en[2] = 1'b1; b_ad[2] = 1;
        run(1'b1, 2, "R5 wide bank conflict", 1'b0);
        check("R5 wide lane0", got[0], mval(0));
        check("R5 wide lane1", got[1], mval(64));
        check("R5 wide lane2", got[2], mval(1));
    endtask

    task automatic t_stride3();
        clear_lanes();
        for (int i = 0; i < SM_LANES; i++) begin b_en[i] = 1'b1; b_ad[i] = 3 * i; end
        run(1'b0, 1, "R6 stride3", 1'b0);
        for (int i = 0; i < SM_LANES; i++) check("R6 stride3 data", got[i], mval(3 * i));
    endtask

    task automatic t_broadcast();
        clear_lanes();
        for (int i = 0; i < SM_LANES; i++) begin b_en[i] = 1'b1; b_ad[i] = 5; end
        run(1'b0, 1, "R4 broadcast", 1'b0);
        for (int i = 0; i < SM_LANES; i++) check("R4 broadcast data", got[i], mval(5));
    endtask

    task automatic t_groups();
        clear_lanes();
        for (int i = 0; i < SM_LANES; i++) begin b_en[i] = 1'b1; b_ad[i] = (i % 4) * 32; end
        run(1'b0, 4, "R3 four-way", 1'b0);
        for (int i = 0; i < SM_LANES; i++) check("R3 four-way data", got[i], mval((i % 4) * 32));
    endtask

    task automatic t_worst();
        clear_lanes();
        for (int i = 0; i < SM_LANES; i++) begin
            b_en[i] = 1'b1; b_we[i] = 1'b1; b_ad[i] = i * 32 + 17; b_wd[i] = 32'h7700_0000 + 32'(i);
        end
        run(1'b0, 32, "R3 32-way write", 1'b1);
        clear_lanes();
        for (int i = 0; i < SM_LANES; i++) begin b_en[i] = 1'b1; b_ad[i] = i * 32 + 17; end
        b_ad[31] = 10;
        run(1'b0, 31, "R3 31-way read", 1'b0);
        for (int i = 0; i < SM_LANES - 1; i++) check("R3 32-way data", got[i], 32'h7700_0000 + 32'(i));
        check("R7 ignored write absent", got[31], mval(10));
    endtask

    task automatic t_mixed();
        clear_lanes();
        for (int i = 0; i < 3; i++) begin b_en[i] = 1'b1; b_ad[i] = 7; end
        b_en[3] = 1'b1; b_we[3] = 1'b1; b_ad[3] = 7;  b_wd[3] = 32'h1111_1111;
        b_en[4] = 1'b1; b_we[4] = 1'b1; b_ad[4] = 40; b_wd[4] = 32'h2222_2222;
        b_en[9] = 1'b1; b_we[9] = 1'b1; b_ad[9] = 40; b_wd[9] = 32'h3333_3333;
        run(1'b0, 1, "R8 mixed pass", 1'b0);
        for (int i = 0; i < 3; i++) check("R8 read old value", got[i], mval(7));
        check("R10 disabled lane zero", got[20], 32'h0);
        clear_lanes();
        b_en[0] = 1'b1; b_ad[0] = 7;
        b_en[1] = 1'b1; b_ad[1] = 40;
        run(1'b0, 1, "R8 readback", 1'b0);
        check("R8 write stored", got[0], 32'h1111_1111);
        check("R8 highest lane wins", got[1], 32'h3333_3333);
        check("R10 disabled lane zero after read", got[5], 32'h0);
    endtask

    task automatic t_empty();
        clear_lanes();
        run(1'b0, 1, "R10 empty request", 1'b0);
        check("R10 empty rdata", got[0], 32'h0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<200000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_linear_read();
        t_stride2();
        t_wide_conflict();
        t_stride3();
        t_broadcast();
        t_groups();
        t_worst();
        t_mixed();
        t_empty();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule